// File: doc/BRIEF.md
# USB Full-Speed Receive Packet Front End

This block sits behind the clock and data recovery of a full-speed USB receiver. Each time the recovery logic asserts `bit_en`, the block samples one line symbol: the differential level (`rx_j` high for J, low for K) and a single-ended-zero flag. It undoes the NRZI line code and strips the stuffed zeros. It waits for the SYNC field, then hands the packet out one byte at a time. The first byte, the PID, is flagged and checked. The packet ends at a proper end-of-packet marker.

Four error classes are kept as sticky flags, and the next SYNC clears them. They are a malformed PID, a bad CRC, a bit-stuffing violation, and a timeout. The timeout covers a packet that runs past its largest legal length and never ends. Token packets are checked against a 5-bit CRC and data packets against a 16-bit CRC. Handshake and special packets carry no check. Everything the block drives is registered and changes on the clock edge on which the symbol is sampled.

Top module: `usb_rx_frontend`

## Requirements
- R1: On each non-SE0 bit time the decoded bit is 1 when the level equals the previous level and 0 when it differs. The previous level counts as J after reset and after any SE0 bit time.
- R2: A decoded 0 that follows six consecutive decoded 1s is discarded and never reaches the byte stream or the CRC.
- R3: While hunting, the last eight decoded bits, in arrival order 0,0,0,0,0,0,0,1, mark a SYNC. This raises `pkt_start` for one cycle and starts a new packet.
- R4: Inside a packet, a seventh consecutive decoded 1 sets `err_stuff`. The rest of that packet produces no bytes and no CRC verdict.
- R5: Packet bits are packed least significant bit first. Each completed byte pulses `byte_valid` with the byte on `byte_data`. `byte_first` accompanies only the PID byte.
- R6: `pid_code` takes the low nibble of the PID byte. PID low bits 01 mark a token, 11 mark data, and anything else means no CRC is checked.
- R7: `err_pid` is set when the PID's upper nibble is not the bitwise inverse of its lower nibble.
- R8: CRC registers are preset to all ones at SYNC and run over every non-PID bit. At end of packet, `err_crc` is set when a token does not leave residue 5'b01100 (polynomial x^5+x^2+1, shift toward the MSB) or when a data packet does not leave 16'h800D (x^16+x^15+x^2+1).
- R9: End of packet is at least two SE0 bit times followed by a non-SE0 bit time. Within a packet it pulses `pkt_end`, discards any partial byte, and returns to hunting.
- R10: Bytes past the first MAX_BYTES of a packet are dropped. The TIMEOUT_BITS-th bit time after the first dropped byte sets `err_timeout`, pulses `pkt_end` and returns to hunting, unless an end of packet comes first.
- R11: After reset all outputs are zero. The four error flags stay set until the next SYNC clears them.
- R12: `pkt_start`, `byte_valid` and `pkt_end` last one cycle, appear only in the cycle after a `bit_en` sample, and never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One pulse per recovered bit time |
| rx_j | input | 1 | Differential line level, 1 = J, 0 = K |
| rx_se0 | input | 1 | Single-ended zero seen this bit time |
| pkt_start | output | 1 | SYNC found, new packet begins |
| byte_valid | output | 1 | `byte_data` holds a packet byte |
| byte_first | output | 1 | Current byte is the PID |
| byte_data | output | 8 | Received byte |
| pkt_end | output | 1 | Packet finished (end marker or timeout) |
| pid_code | output | 4 | Low nibble of the last PID |
| err_pid | output | 1 | Sticky PID check failure |
| err_crc | output | 1 | Sticky CRC failure |
| err_stuff | output | 1 | Sticky stuffing violation |
| err_timeout | output | 1 | Sticky end-of-packet timeout |

## Verification
The hardest case to reach is the timeout. It needs a packet longer than the byte limit, and the line must keep toggling after that so that a stuffing violation does not end the packet first. The bench builds the instance with a small byte limit and a short timeout. It then streams a data packet made of alternating bits, whose decoded pattern neither stuffs nor looks like SYNC, well past the limit before any end marker. The stuffing violation is reached by turning off the bench's own stuffer for one packet that carries two 0xFF bytes.

// File: rtl/usb_rx_pkg.sv
// Package: shared state type, constants and CRC step functions for the
// USB receive front end. Assumes bits arrive least significant first.
package usb_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_PID   = 2'd1,
        ST_BODY  = 2'd2,
        ST_DRAIN = 2'd3
    } rx_state_t;

    localparam logic [7:0]  SYNC_WORD     = 8'h80;
    localparam logic [4:0]  CRC5_PRESET   = 5'h1F;
    localparam logic [15:0] CRC16_PRESET  = 16'hFFFF;
    localparam logic [4:0]  CRC5_RESIDUE  = 5'b01100;
    localparam logic [15:0] CRC16_RESIDUE = 16'h800D;
    localparam logic [4:0]  CRC5_POLY     = 5'h05;
    localparam logic [15:0] CRC16_POLY    = 16'h8005;
    localparam logic [1:0]  KIND_TOKEN    = 2'b01;
    localparam logic [1:0]  KIND_DATA     = 2'b11;

    // One serial step of the 5-bit token check.
    function automatic logic [4:0] crc5_step(input logic [4:0] c, input logic b);
        logic fb;
        fb = b ^ c[4];
        return {c[3:0], 1'b0} ^ (fb ? CRC5_POLY : 5'h00);
    endfunction

    // One serial step of the 16-bit data check.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = b ^ c[15];
        return {c[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/usb_rx_nrzi.sv
// Line decoder: turns sampled line symbols into NRZI-decoded bits and
// recognises the end-of-packet marker (two or more SE0 bit times, then a
// non-SE0 bit time). Assumes bit_en is high for exactly one clock per bit.
module usb_rx_nrzi #(
    parameter int EOP_SE0_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_j,
    input  logic rx_se0,
    output logic dec_valid,
    output logic dec_bit,
    output logic eop
);
    localparam int RUN_W = $clog2(EOP_SE0_BITS + 1);

    logic             prev_j;
    logic [RUN_W-1:0] se0_run;
    logic             run_full;
    logic             line_bit;

    // Track the previous level and the length of the current SE0 run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_j  <= 1'b1;
            se0_run <= '0;
        end else if (bit_en) begin
            if (rx_se0) begin
                prev_j  <= 1'b1;
                if (!run_full) se0_run <= se0_run + 1'b1;
            end else begin
                prev_j  <= rx_j;
                se0_run <= '0;
            end
        end
    end

    // Decode the current symbol against the previous level.
    always_comb begin
        run_full  = (se0_run == RUN_W'(EOP_SE0_BITS));
        line_bit  = bit_en && !rx_se0;
        eop       = line_bit && run_full;
        dec_valid = line_bit && !run_full;
        dec_bit   = (rx_j == prev_j);
    end

endmodule

// File: rtl/usb_rx_unstuff.sv
// Run-length tracker for bit destuffing: flags the zero that follows a run
// of RUN_LIMIT ones (to be dropped) and a one that extends such a run
// (a violation). Assumes the run restarts at every end of packet.
module usb_rx_unstuff #(
    parameter int RUN_LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_valid,
    input  logic dec_bit,
    input  logic eop,
    output logic is_stuff,
    output logic violation
);
    localparam int ONES_W = $clog2(RUN_LIMIT + 1);

    logic [ONES_W-1:0] ones_run;
    logic              at_limit;

    // Count consecutive decoded ones, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_run <= '0;
        end else if (eop) begin
            ones_run <= '0;
        end else if (dec_valid) begin
            if (!dec_bit)      ones_run <= '0;
            else if (!at_limit) ones_run <= ones_run + 1'b1;
        end
    end

    // Classify the incoming bit against the current run.
    always_comb begin
        at_limit  = (ones_run == ONES_W'(RUN_LIMIT));
        is_stuff  = dec_valid && !dec_bit && at_limit;
        violation = dec_valid &&  dec_bit && at_limit;
    end

endmodule

// File: rtl/usb_rx_crc.sv
// Serial CRC pair: runs both the 5-bit and the 16-bit check over the same
// bits and reports whether each register holds its good-packet residue.
// Assumes clear and en are never high together.
module usb_rx_crc (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    input  logic din,
    output logic crc5_ok,
    output logic crc16_ok
);
    import usb_rx_pkg::*;

    logic [4:0]  crc5_q;
    logic [15:0] crc16_q;

    // Preset on clear, otherwise shift in one bit per enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc5_q  <= CRC5_PRESET;
            crc16_q <= CRC16_PRESET;
        end else if (en) begin
            crc5_q  <= crc5_step(crc5_q, din);
            crc16_q <= crc16_step(crc16_q, din);
        end
    end

    // Compare against the residues of a correct packet.
    always_comb begin
        crc5_ok  = (crc5_q == CRC5_RESIDUE);
        crc16_ok = (crc16_q == CRC16_RESIDUE);
    end

    assert_preset_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc5_q == CRC5_PRESET && crc16_q == CRC16_PRESET));

endmodule

// File: rtl/usb_rx_frontend.sv
// USB full-speed receive front end: SYNC hunt, PID check, byte assembly,
// CRC verdict, end-of-packet and timeout handling, sticky error flags.
// Assumes one bit_en pulse per bit time from upstream clock recovery.
module usb_rx_frontend #(
    parameter int MAX_BYTES    = 1027,
    parameter int TIMEOUT_BITS = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       rx_j,
    input  logic       rx_se0,
    output logic       pkt_start,
    output logic       byte_valid,
    output logic       byte_first,
    output logic [7:0] byte_data,
    output logic       pkt_end,
    output logic [3:0] pid_code,
    output logic       err_pid,
    output logic       err_crc,
    output logic       err_stuff,
    output logic       err_timeout
);
    import usb_rx_pkg::*;

    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam int TMO_W = $clog2(TIMEOUT_BITS + 1);

    rx_state_t   state;
    logic [7:0]  sync_sh;
    logic [7:0]  byte_sh;
    logic [2:0]  bit_idx;
    logic [CNT_W-1:0] byte_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic        over;
    logic [1:0]  kind;

    logic dec_valid, dec_bit, eop;
    logic is_stuff, violation;
    logic crc5_ok, crc16_ok;
    logic [7:0] sync_next;
    logic [7:0] byte_next;
    logic sync_hit, in_packet, tmo_fire, take_bit, crc_bad;

    usb_rx_nrzi #(.EOP_SE0_BITS(2)) u_nrzi (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_j(rx_j), .rx_se0(rx_se0),
        .dec_valid(dec_valid), .dec_bit(dec_bit), .eop(eop)
    );

    usb_rx_unstuff #(.RUN_LIMIT(6)) u_unstuff (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_bit(dec_bit),
        .eop(eop), .is_stuff(is_stuff), .violation(violation)
    );

    usb_rx_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(sync_hit),
        .en(take_bit && state == ST_BODY), .din(dec_bit),
        .crc5_ok(crc5_ok), .crc16_ok(crc16_ok)
    );

    // Combinational decisions for the current bit time.
    always_comb begin
        sync_next = {dec_bit, sync_sh[7:1]};
        byte_next = {dec_bit, byte_sh[7:1]};
        in_packet = (state != ST_HUNT);
        sync_hit  = dec_valid && state == ST_HUNT && sync_next == SYNC_WORD;
        tmo_fire  = bit_en && !eop && in_packet && over
                    && tmo_cnt == TMO_W'(TIMEOUT_BITS - 1);
        take_bit  = dec_valid && !tmo_fire && !is_stuff && !violation
                    && (state == ST_PID || state == ST_BODY);
        crc_bad   = (kind == KIND_TOKEN && !crc5_ok) || (kind == KIND_DATA && !crc16_ok);
    end

    // Packet sequencing, byte assembly and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_HUNT;
            sync_sh     <= 8'hFF;
            byte_sh     <= '0;
            bit_idx     <= '0;
            byte_cnt    <= '0;
            tmo_cnt     <= '0;
            over        <= 1'b0;
            kind        <= '0;
            pkt_start   <= 1'b0;
            byte_valid  <= 1'b0;
            byte_first  <= 1'b0;
            byte_data   <= '0;
            pkt_end     <= 1'b0;
            pid_code    <= '0;
            err_pid     <= 1'b0;
            err_crc     <= 1'b0;
            err_stuff   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            pkt_start  <= 1'b0;
            byte_valid <= 1'b0;
            byte_first <= 1'b0;
            pkt_end    <= 1'b0;
            if (bit_en && in_packet && over) tmo_cnt <= tmo_cnt + 1'b1;
            if (eop) begin
                if (in_packet) pkt_end <= 1'b1;
                if (state == ST_BODY && crc_bad) err_crc <= 1'b1;
                state   <= ST_HUNT;
                sync_sh <= 8'hFF;
            end else if (tmo_fire) begin
                err_timeout <= 1'b1;
                pkt_end     <= 1'b1;
                state       <= ST_HUNT;
                sync_sh     <= 8'hFF;
            end else if (dec_valid) begin
                if (state == ST_HUNT) begin
                    sync_sh <= sync_next;
                    if (sync_hit) begin
                        state       <= ST_PID;
                        pkt_start   <= 1'b1;
                        err_pid     <= 1'b0;
                        err_crc     <= 1'b0;
                        err_stuff   <= 1'b0;
                        err_timeout <= 1'b0;
                        bit_idx     <= '0;
                        byte_cnt    <= '0;
                        tmo_cnt     <= '0;
                        over        <= 1'b0;
                    end
                end else if ((state == ST_PID || state == ST_BODY) && violation) begin
                    err_stuff <= 1'b1;
                    state     <= ST_DRAIN;
                end else if (take_bit) begin
                    byte_sh <= byte_next;
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == 3'd7) begin
                        if (byte_cnt == CNT_W'(MAX_BYTES)) begin
                            if (!over) tmo_cnt <= '0;
                            over <= 1'b1;
                        end else begin
                            byte_valid <= 1'b1;
                            byte_first <= (state == ST_PID);
                            byte_data  <= byte_next;
                            byte_cnt   <= byte_cnt + 1'b1;
                        end
                        if (state == ST_PID) begin
                            pid_code <= byte_next[3:0];
                            kind     <= byte_next[1:0];
                            err_pid  <= (byte_next[7:4] != ~byte_next[3:0]);
                            state    <= ST_BODY;
                        end
                    end
                end
            end
        end
    end

    assert_single_marker_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_start, byte_valid, pkt_end}));
    assert_pulse_follows_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start || byte_valid || pkt_end) |-> $past(bit_en));
    assert_start_clears_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |-> !(err_pid || err_crc || err_stuff || err_timeout));
    assert_sticky_stuff_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_stuff |=> (err_stuff || pkt_start));
    assert_sticky_crc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_crc |=> (err_crc || pkt_start));
    assert_first_is_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_first |-> byte_valid);
    assert_timeout_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> pkt_end);
    assert_violation_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !eop && !tmo_fire && (state == ST_PID || state == ST_BODY)) |=> err_stuff);

endmodule

// File: tb/test_usb_rx_frontend.sv
module test_usb_rx_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 6;
    localparam int TMOB = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, rx_j = 1'b1, rx_se0 = 1'b0;
    logic pkt_start, byte_valid, byte_first, pkt_end;
    logic [7:0] byte_data;
    logic [3:0] pid_code;
    logic err_pid, err_crc, err_stuff, err_timeout;

    int total = 0, bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    usb_rx_frontend #(.MAX_BYTES(MAXB), .TIMEOUT_BITS(TMOB)) i_usb_rx_frontend (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_j(rx_j), .rx_se0(rx_se0),
        .pkt_start(pkt_start), .byte_valid(byte_valid), .byte_first(byte_first),
        .byte_data(byte_data), .pkt_end(pkt_end), .pid_code(pid_code),
        .err_pid(err_pid), .err_crc(err_crc), .err_stuff(err_stuff),
        .err_timeout(err_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_prev, m_se0, m_ones, m_state, m_sh, m_bidx, m_byte, m_cnt, m_over, m_tmo, m_kind;
    bit m_body[$];
    int e_start, e_bv, e_first, e_data, e_end, e_pid, e_epid, e_ecrc, e_estuff, e_etmo;

    function automatic bit body_crc_bad(int k);
        int c5 = 5'h1F;
        int c16 = 16'hFFFF;
        foreach (m_body[i]) begin
            int f5 = m_body[i] ^ ((c5 >> 4) & 1);
            int f16 = m_body[i] ^ ((c16 >> 15) & 1);
            c5 = ((c5 << 1) & 5'h1F) ^ (f5 ? 5 : 0);
            c16 = ((c16 << 1) & 16'hFFFF) ^ (f16 ? 16'h8005 : 0);
        end
        if (k == 1) return c5 != 5'b01100;
        if (k == 3) return c16 != 16'h800D;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 1; m_se0 = 0; m_ones = 0; m_state = 0; m_sh = 8'hFF;
            m_bidx = 0; m_byte = 0; m_cnt = 0; m_over = 0; m_tmo = 0; m_kind = 0;
            e_start = 0; e_bv = 0; e_first = 0; e_data = 0; e_end = 0; e_pid = 0;
            e_epid = 0; e_ecrc = 0; e_estuff = 0; e_etmo = 0;
        end else begin
            e_start = 0; e_bv = 0; e_first = 0; e_end = 0;
            if (bit_en) begin
                bit is_eop, dv, d, stf, vio, fire;
                is_eop = !rx_se0 && m_se0 == 2;
                dv = !rx_se0 && m_se0 != 2;
                d = (rx_j == m_prev);
                if (rx_se0) begin m_prev = 1; if (m_se0 < 2) m_se0++; end
                else begin m_prev = rx_j; m_se0 = 0; end
                stf = dv && !d && m_ones == 6;
                vio = dv && d && m_ones == 6;
                if (is_eop) m_ones = 0;
                else if (dv) m_ones = d ? ((m_ones < 6) ? m_ones + 1 : 6) : 0;
                fire = !is_eop && m_state != 0 && m_over && m_tmo == TMOB - 1;
                if (is_eop) begin
                    if (m_state != 0) e_end = 1;
                    if (m_state == 2 && body_crc_bad(m_kind)) e_ecrc = 1;
                    m_state = 0; m_sh = 8'hFF;
                end else if (fire) begin
                    e_etmo = 1; e_end = 1; m_state = 0; m_sh = 8'hFF;
                end else begin
                    if (m_over && m_state != 0) m_tmo++;
                    if (dv) begin
                        if (m_state == 0) begin
                            m_sh = (m_sh >> 1) | (d << 7);
                            if (m_sh == 8'h80) begin
                                m_state = 1; e_start = 1; e_epid = 0; e_ecrc = 0;
                                e_estuff = 0; e_etmo = 0; m_bidx = 0; m_cnt = 0;
                                m_over = 0; m_tmo = 0; m_body.delete();
                            end
                        end else if (m_state == 3) begin
                        end else if (vio) begin
                            e_estuff = 1; m_state = 3;
                        end else if (!stf) begin
                            if (m_state == 2) m_body.push_back(d);
                            m_byte = (m_byte >> 1) | (d << 7);
                            if (m_bidx == 7) begin
                                m_bidx = 0;
                                if (m_cnt == MAXB) begin
                                    if (!m_over) m_tmo = 0;
                                    m_over = 1;
                                end else begin
                                    e_bv = 1; e_first = (m_state == 1); e_data = m_byte; m_cnt++;
                                end
                                if (m_state == 1) begin
                                    e_pid = m_byte & 15; m_kind = m_byte & 3;
                                    e_epid = ((m_byte >> 4) != (~m_byte & 15));
                                    m_state = 2;
                                end
                            end else m_bidx++;
                        end
                    end
                end
            end
        end
    end

    // Compare the design with the reference after every clock edge.
    int got_bytes[$];
    always @(posedge clk) begin
        #2;
        if (cmp_on && !done) begin
            total++;
            if (pkt_start !== e_start[0] || byte_valid !== e_bv[0] || byte_first !== e_first[0]
                || pkt_end !== e_end[0] || (byte_valid && byte_data !== e_data[7:0])
                || pid_code !== e_pid[3:0] || err_pid !== e_epid[0] || err_crc !== e_ecrc[0]
                || err_stuff !== e_estuff[0] || err_timeout !== e_etmo[0]) begin
                bad++;
                $display("FAIL R12/R3/R5/R9 model: start=%b/%0d byte=%b/%0d data=%h/%h end=%b/%0d pid=%h/%h",
                         pkt_start, e_start, byte_valid, e_bv, byte_data, e_data[7:0], pkt_end, e_end,
                         pid_code, e_pid[3:0]);
                $display("FAIL R4/R7/R8/R10 model flags: pid=%b/%0d crc=%b/%0d stuff=%b/%0d tmo=%b/%0d",
                         err_pid, e_epid, err_crc, e_ecrc, err_stuff, e_estuff, err_timeout, e_etmo);
            end
            if (byte_valid) got_bytes.push_back(byte_data);
        end
    end

    // ---------------- stimulus ----------------
    bit tx_bits[$];
    bit lvl = 1;
    int ones_tx = 0;

    task automatic send_sym(input bit j, input bit se0);
        @(negedge clk);
        rx_j = j; rx_se0 = se0; bit_en = 1;
        @(negedge clk);
        bit_en = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input bit stuff_on);
        if (!b) lvl = ~lvl;
        send_sym(lvl, 0);
        ones_tx = b ? ones_tx + 1 : 0;
        if (stuff_on && ones_tx == 6) begin
            lvl = ~lvl; send_sym(lvl, 0); ones_tx = 0;
        end
    endtask

    task automatic add_byte(input int b);
        for (int i = 0; i < 8; i++) tx_bits.push_back((b >> i) & 1);
    endtask

    task automatic add_crc(input int start, input bit wide);
        int c = wide ? 16'hFFFF : 5'h1F;
        int w = wide ? 16 : 5;
        for (int i = start; i < tx_bits.size(); i++) begin
            int f = tx_bits[i] ^ ((c >> (w - 1)) & 1);
            c = (c << 1) & ((1 << w) - 1);
            if (f) c ^= wide ? 16'h8005 : 5;
        end
        for (int i = w - 1; i >= 0; i--) tx_bits.push_back(~(c >> i) & 1);
    endtask

    task automatic transmit(input bit stuff_on, input bit with_eop);
        ones_tx = 0;
        for (int i = 0; i < 7; i++) send_bit(0, stuff_on);
        send_bit(1, stuff_on);
        foreach (tx_bits[i]) send_bit(tx_bits[i], stuff_on);
        if (with_eop) begin
            send_sym(0, 1); send_sym(0, 1); send_sym(1, 0); lvl = 1;
        end
        repeat (3) send_sym(lvl, 0);
    endtask

    task automatic check_bytes(input string req, input int nexp);
        chk({req, " byte count"}, got_bytes.size(), nexp);
        for (int i = 0; i < nexp && i < got_bytes.size(); i++) begin
            int e = 0;
            for (int k = 0; k < 8; k++) e |= tx_bits[i*8+k] << k;
            chk({req, " byte value"}, got_bytes[i], e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1; bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset pkt_end", pkt_end, 0);
        chk("R11 reset flags", {err_pid, err_crc, err_stuff, err_timeout}, 0);
        cmp_on = 1;
        repeat (4) send_sym(1, 0);

        // R1 R3 R5 R6 R8: valid OUT token, addr 0x15 endp 0xA
        tx_bits.delete(); got_bytes.delete();
        add_byte(8'hE1);
        for (int i = 0; i < 7; i++) tx_bits.push_back((7'h15 >> i) & 1);
        for (int i = 0; i < 4; i++) tx_bits.push_back((4'hA >> i) & 1);
        add_crc(8, 0);
        transmit(1, 1);
        check_bytes("R5 token", 3);
        chk("R6 token pid", pid_code, 4'h1);
        chk("R8 token crc good", err_crc, 0);
        chk("R7 token pid ok", err_pid, 0);

        // R2: DATA0 with FF bytes forcing stuffed zeros, good CRC16
        tx_bits.delete(); got_bytes.delete();
        add_byte(8'hC3); add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h7E);
        add_crc(8, 1);
        transmit(1, 1);
        check_bytes("R2 data stuffed", 6);
        chk("R2 no stuff error", err_stuff, 0);
        chk("R8 data crc good", err_crc, 0);
        chk("R6 data pid", pid_code, 4'h3);

        // R8: corrupt CRC16
        tx_bits.delete(); got_bytes.delete();
        add_byte(8'h4B); add_byte(8'h12); add_byte(8'h34);
        add_crc(8, 1);
        tx_bits[10] = ~tx_bits[10];
        transmit(1, 1);
        chk("R8 bad crc flagged", err_crc, 1);
        repeat (10) send_sym(1, 0);
        chk("R11 crc flag sticky", err_crc, 1);

        // R7 R11: ACK handshake clears flags; then PID error
        tx_bits.delete(); got_bytes.delete();
        add_byte(8'hD2);
        transmit(1, 1);
        chk("R11 flags cleared by sync", err_crc, 0);
        chk("R6 handshake pid", pid_code, 4'h2);
        tx_bits.delete(); got_bytes.delete();
        add_byte(8'h12);
        transmit(1, 1);
        chk("R7 pid error", err_pid, 1);

        // R4: stuffing violation
        tx_bits.delete(); got_bytes.delete();
        add_byte(8'hC3); add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h00);
        transmit(0, 1);
        chk("R4 stuff error", err_stuff, 1);
        chk("R4 no bytes after violation", got_bytes.size(), 1);
        chk("R4 no crc verdict", err_crc, 0);

        // R10: over-long data packet with no end marker
        tx_bits.delete(); got_bytes.delete();
        add_byte(8'hC3);
        for (int i = 0; i < 12; i++) add_byte(8'h55);
        transmit(1, 0);
        chk("R10 timeout flag", err_timeout, 1);
        chk("R10 bytes capped", got_bytes.size(), MAXB);
        send_sym(0, 1); send_sym(0, 1); send_sym(1, 0); lvl = 1;
        repeat (3) send_sym(1, 0);

        // R9 R11: normal packet after timeout
        tx_bits.delete(); got_bytes.delete();
        add_byte(8'hC3); add_byte(8'hA5);
        add_crc(8, 1);
        transmit(1, 1);
        chk("R11 timeout cleared", err_timeout, 0);
        check_bytes("R9 packet after timeout", 4);
        chk("R8 crc ok after timeout", err_crc, 0);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule